// File: doc/BRIEF.md
# Barrett Modular Arithmetic Unit

This unit carries out one modular operation per clock on residues of a prime modulus `q` that is up to `W` bits wide (32 by default). A 3-bit opcode picks the operation: modular multiply, reduction of a double-width value, modular add, modular subtract, a transform butterfly, or multiply-accumulate into an internal accumulator. All multiplicative results are reduced with Barrett's method. The modulus and its Barrett constant `mu = floor(2^(2W) / q)` arrive with every operation on the constants port, so a caller can change the modulus from one cycle to the next.

The unit is a three-stage pipeline with one shared datapath. It has three multipliers: one for the operand product, one for the quotient estimate and one for quotient times modulus. Every operation takes exactly three cycles. A new operation may be issued on every cycle, and results leave in issue order, each marked by `valid_out`.

Top module: `mod_arith_unit`

## Requirements
- R1: Opcode 0 (multiply) returns `res0 = (a*b) mod q` for any W-bit `a` and `b`.
- R2: Opcode 1 (reduce) returns `res0 = X mod q`, where the 2W-bit value X has `a` as its upper half and `b` as its lower half.
- R3: Opcode 2 (add) returns `res0 = (a+b) mod q` when `a` and `b` are both below `q`.
- R4: Opcode 3 (subtract) returns `res0 = (a-b) mod q`, always non-negative, when `a` and `b` are both below `q`.
- R5: Opcode 4 (butterfly) forms `t = (b*w) mod q` and returns `res0 = (a+t) mod q` and `res1 = (a-t) mod q` when `a < q`. Every other opcode returns `res1 = 0`.
- R6: Opcode 5 (multiply-accumulate) sets the accumulator to `(base + (a*b mod q)) mod q` and returns the new value on `res0`. `base` is the accumulator, or 0 when `acc_clr` is 1.
- R7: Opcodes 6 and 7 return 0 on both results and leave the accumulator unchanged.
- R8: Each cycle with `valid_in` high produces exactly one cycle of `valid_out` three clock edges later. Results keep issue order, and the unit accepts one operation on every cycle.
- R9: The modulus and `mu` are taken with each operation, so back-to-back operations may use different moduli (any `q >= 2`).
- R10: While `rst_n` is low, `valid_out`, `res0` and `res1` are 0 and the accumulator is cleared. After reset, the first accumulate without clear therefore starts from 0.
- R11: Every result returned is below the modulus of its operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| valid_in | input | 1 | Operation issued this cycle |
| op | input | 3 | Opcode (0 mul, 1 reduce, 2 add, 3 sub, 4 butterfly, 5 accumulate) |
| acc_clr | input | 1 | Accumulate starts from zero instead of the accumulator |
| a | input | W | First operand; upper half for reduce |
| b | input | W | Second operand; lower half for reduce |
| w | input | W | Butterfly twiddle factor |
| q | input | W | Modulus for this operation |
| mu | input | 2W | Barrett constant floor(2^(2W)/q) |
| valid_out | output | 1 | Results valid |
| res0 | output | W | Main result (butterfly sum) |
| res1 | output | W | Butterfly difference; 0 otherwise |

## Verification
The bench runs the unit at an 8-bit width, where it can sweep operands almost exhaustively. Multiply is swept over every pair of 8-bit operands with a modulus just under 2^8. This exercises the largest quotient errors, so it shows whether the two correction subtractions are really needed. Reduce, add, subtract and butterfly are swept over grids of in-range operands with tiny moduli (2, 3, 13) and a large one. The tiny moduli expose errors in the quotient estimate that a large modulus would hide. Accumulate chains with scattered clears, invalid opcodes placed in such a chain, idle gaps, and a stream that changes the modulus on every cycle separate errors in accumulator ordering, constant capture and pipeline timing.

// File: rtl/mod_arith_unit.sv
module mod_arith_unit #(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           valid_in,
  input  logic [2:0]     op,
  input  logic           acc_clr,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  logic [W-1:0]   w,
  input  logic [W-1:0]   q,
  input  logic [2*W-1:0] mu,
  output logic           valid_out,
  output logic [W-1:0]   res0,
  output logic [W-1:0]   res1
);
  localparam int XW = 2 * W;
  localparam int PW = 2 * XW;
  localparam logic [2:0] OP_MUL = 3'd0;
  localparam logic [2:0] OP_RED = 3'd1;
  localparam logic [2:0] OP_ADD = 3'd2;
  localparam logic [2:0] OP_SUB = 3'd3;
  localparam logic [2:0] OP_BFY = 3'd4;
  localparam logic [2:0] OP_MAC = 3'd5;

  // stage 1: operand steering and product
  logic [XW-1:0] x_d;
  always_comb begin
    case (op)
      OP_RED:         x_d = {a, b};
      OP_ADD, OP_SUB: x_d = XW'(b);
      OP_BFY:         x_d = XW'(b) * XW'(w);
      default:        x_d = XW'(a) * XW'(b);
    endcase
  end

  logic          v1, clr1;
  logic [2:0]    op1;
  logic [W-1:0]  a1, q1;
  logic [XW-1:0] mu1, x1;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v1 <= 1'b0; clr1 <= 1'b0; op1 <= '0;
      a1 <= '0; q1 <= '0; mu1 <= '0; x1 <= '0;
    end else begin
      v1 <= valid_in; clr1 <= acc_clr; op1 <= op;
      a1 <= a; q1 <= q; mu1 <= mu; x1 <= x_d;
    end
  end

  // stage 2: quotient estimate
  logic [PW-1:0] est;
  logic [XW-1:0] qh_d;
  assign est  = PW'(x1) * PW'(mu1);
  assign qh_d = XW'(est >> XW);

  logic          v2, clr2;
  logic [2:0]    op2;
  logic [W-1:0]  a2, q2;
  logic [XW-1:0] x2, qh2;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v2 <= 1'b0; clr2 <= 1'b0; op2 <= '0;
      a2 <= '0; q2 <= '0; x2 <= '0; qh2 <= '0;
    end else begin
      v2 <= v1; clr2 <= clr1; op2 <= op1;
      a2 <= a1; q2 <= q1; x2 <= x1; qh2 <= qh_d;
    end
  end

  // stage 3: remainder correction and final combine
  logic [XW-1:0] rem_full;
  logic [W:0]    r0, r1, r2, qe, sum, sm;
  logic [W-1:0]  t, base, df;
  logic [W-1:0]  acc;
  logic [W-1:0]  n0, n1;

  assign rem_full = x2 - qh2 * XW'(q2);
  assign qe   = {1'b0, q2};
  assign r0   = (W+1)'(rem_full);
  assign r1   = (r0 >= qe) ? r0 - qe : r0;
  assign r2   = (r1 >= qe) ? r1 - qe : r1;
  assign t    = W'(r2);
  assign base = (op2 == OP_MAC) ? (clr2 ? '0 : acc) : a2;
  assign sum  = {1'b0, base} + {1'b0, t};
  assign sm   = (sum >= qe) ? sum - qe : sum;
  assign df   = base - t + ((base < t) ? q2 : '0);

  always_comb begin
    n0 = '0;
    n1 = '0;
    case (op2)
      OP_MUL, OP_RED: n0 = t;
      OP_ADD, OP_MAC: n0 = W'(sm);
      OP_SUB:         n0 = df;
      OP_BFY: begin
        n0 = W'(sm);
        n1 = df;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_out <= 1'b0; res0 <= '0; res1 <= '0; acc <= '0;
    end else begin
      valid_out <= v2;
      if (v2) begin
        res0 <= n0;
        res1 <= n1;
      end
      if (v2 && op2 == OP_MAC) acc <= W'(sm);
    end
  end

  assert_rem_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    v2 |-> (rem_full < (XW'(q2) << 1)));

  assert_res_below_q_R11: assert property (@(posedge clk) disable iff (!rst_n)
    valid_out |-> (res0 < $past(q2) && res1 < $past(q2)));

  assert_acc_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(v2 && op2 == OP_MAC) |=> $stable(acc));

  assert_res1_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_out && $past(op2) != OP_BFY) |-> res1 == '0);
endmodule

// File: tb/mod_arith_unit_bench.sv
module mod_arith_unit_bench;
  localparam int W = 8;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic           rst_n = 1'b0;
  logic           valid_in = 1'b0;
  logic [2:0]     op = '0;
  logic           acc_clr = 1'b0;
  logic [W-1:0]   a = '0, b = '0, w = '0, q = 8'd13;
  logic [2*W-1:0] mu = '0;
  logic           valid_out;
  logic [W-1:0]   res0, res1;

  mod_arith_unit #(.W(W)) u_mod_arith_unit (
    .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .op(op), .acc_clr(acc_clr),
    .a(a), .b(b), .w(w), .q(q), .mu(mu),
    .valid_out(valid_out), .res0(res0), .res1(res1));

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_cmp = 0, n_bad = 0;
  int e_cyc [16];
  longint e_r0 [16], e_r1 [16];
  int e_req [16];
  logic [3:0] wp = '0, rp = '0;
  longint model_acc = 0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic issue(input int o, input int qq, input longint aa, input longint bb,
                       input longint ww, input bit clr, input int req);
    longint r0x, r1x, tt, bs;
    r0x = 0; r1x = 0;
    case (o)
      0: r0x = (aa * bb) % qq;
      1: r0x = ((aa << W) | bb) % qq;
      2: r0x = (aa + bb) % qq;
      3: r0x = (aa - bb + qq) % qq;
      4: begin
        tt = (bb * ww) % qq;
        r0x = (aa + tt) % qq;
        r1x = (aa - tt + qq) % qq;
      end
      5: begin
        bs = clr ? 0 : model_acc;
        r0x = (bs + (aa * bb) % qq) % qq;
        model_acc = r0x;
      end
      default: ;
    endcase
    @(negedge clk);
    valid_in = 1'b1; op = 3'(o); acc_clr = clr;
    a = W'(aa); b = W'(bb); w = W'(ww); q = W'(qq);
    mu = (2*W)'((longint'(1) << (2*W)) / qq);
    e_cyc[wp] = cyc + 3; e_r0[wp] = r0x; e_r1[wp] = r1x; e_req[wp] = req;
    wp = wp + 1'b1;
  endtask

  task automatic idle();
    @(negedge clk);
    valid_in = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (valid_out) begin
        if (rp != wp && e_cyc[rp] == cyc) begin
          check(res0 == W'(e_r0[rp]), $sformatf("R%0d res0", e_req[rp]), res0, e_r0[rp]);
          check(res1 == W'(e_r1[rp]), $sformatf("R%0d res1", e_req[rp]), res1, e_r1[rp]);
          rp = rp + 1'b1;
        end else begin
          check(1'b0, "R8 unexpected valid_out", 1, 0);
        end
      end else if (rp != wp && e_cyc[rp] == cyc) begin
        check(1'b0, "R8 missing valid_out", 0, 1);
        rp = rp + 1'b1;
      end
    end
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    check(1'b0, "watchdog expired", cyc, 0);
    summary();
  end

  initial begin
    int qs [4] = '{2, 3, 13, 251};
    int k;
    repeat (3) @(negedge clk);
    check(valid_out == 1'b0, "R10 valid_out in reset", valid_out, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(valid_out == 1'b0, "R10 valid_out after reset", valid_out, 0);
    check(res0 == '0, "R10 res0 after reset", res0, 0);
    check(res1 == '0, "R10 res1 after reset", res1, 0);

    // R10 / R6: accumulator starts from zero after reset
    issue(5, 13, 3, 4, 0, 0, 10);
    issue(5, 13, 5, 5, 0, 0, 6);

    // small moduli: near-exhaustive sweeps of every opcode
    for (int qi = 0; qi < 3; qi++) begin
      k = qs[qi];
      for (int x = 0; x < 16; x++)
        for (int y = 0; y < 16; y++) begin
          issue(0, k, x, y, 0, 0, 1);                 // R1
          issue(1, k, x * 16, y * 17, 0, 0, 2);       // R2
          issue(4, k, x % k, y, (x + y) % 16, 0, 5);  // R5
          if ((x + y) % 11 == 0) idle();
        end
      for (int x = 0; x < k; x++)
        for (int y = 0; y < k; y++) begin
          issue(2, k, x, y, 0, 0, 3);  // R3
          issue(3, k, x, y, 0, 0, 4);  // R4
        end
      issue(1, k, 255, 255, 0, 0, 2);  // R2
      issue(0, k, 255, 255, 0, 0, 1);  // R1
    end

    // R1: every operand pair for a modulus just below 2^W
    for (int x = 0; x < 256; x++) begin
      for (int y = 0; y < 256; y++) issue(0, 251, x, y, 0, 0, 1);
      idle();
    end
    // R2
    for (int x = 0; x < 256; x += 3)
      for (int y = 0; y < 256; y += 5) issue(1, 251, x, y, 0, 0, 2);
    issue(1, 251, 255, 255, 0, 0, 2);
    // R3, R4
    for (int x = 0; x < 251; x += 2)
      for (int y = 0; y < 251; y += 3) begin
        issue(2, 251, x, y, 0, 0, 3);
        issue(3, 251, x, y, 0, 0, 4);
      end
    issue(2, 251, 250, 250, 0, 0, 3);
    issue(3, 251, 0, 250, 0, 0, 4);
    // R5
    for (int x = 0; x < 251; x += 25)
      for (int y = 0; y < 256; y += 9)
        for (int z = 0; z < 256; z += 9) issue(4, 251, x, y, z, 0, 5);
    issue(4, 251, 250, 255, 255, 0, 5);

    // R6: accumulate chain with scattered clears and gaps
    for (int i = 0; i < 300; i++) begin
      issue(5, 251, (i * 37) % 256, (i * 91 + 5) % 256, 0, (i % 37 == 0), 6);
      if (i % 13 == 0) idle();
    end

    // R7: invalid opcodes return zero and leave the accumulator alone
    issue(5, 251, 200, 201, 0, 1, 6);
    issue(6, 251, 17, 99, 3, 0, 7);
    issue(7, 251, 250, 250, 250, 1, 7);
    idle();
    issue(5, 251, 0, 0, 0, 0, 7);
    issue(5, 13, 12, 12, 0, 1, 6);
    issue(6, 13, 1, 1, 1, 1, 7);
    issue(5, 13, 1, 1, 0, 0, 7);

    // R9: modulus changes on every cycle
    for (int i = 0; i < 600; i++) begin
      k = qs[i % 4];
      issue(i % 5, k, (i * 7) % k, (i * 13) % k, (i * 29) % 256, 0, 9);
    end

    repeat (8) idle();
    check(rp == wp, "R8 all results delivered", rp, wp);
    summary();
  end
endmodule